// File: doc/BRIEF.md
# Programmable Parallel Bus Cycle Sequencer

This block runs strobe cycles for one region of an asynchronous external parallel bus, such as a flash card port used in 8-bit or 16-bit mode. Each cycle has a fixed sequence of phases. The address is presented first. Chip select then falls, and after a lead time the read or write strobe is asserted. The strobe is released, chip select is held for a short time and then released, and an idle gap follows. The length of every phase comes from its own configuration field and is scaled by a common timing multiplier. A device ready input can optionally stretch the strobe.

Local agents use a single request port, with a write flag, address and data. Writes are posted into an eight-entry buffer and reach the bus in the order they were accepted. A read is held off until that buffer is empty and the bus is idle. It then runs its own bus cycle, and the captured data is returned with a one-clock done pulse. A region enable gates all activity on the bus.

The controller is a single state machine with eight states. IDLE waits for work. SETUP presents the address with chip select high. LEAD holds chip select low before the strobe. STROBE asserts the strobe for its programmed width. STALL holds the strobe while the device is not ready. TRAIL keeps the strobe asserted for the extension after ready returns. HOLD releases the strobe and keeps chip select low. GAP releases chip select.

The transitions are as follows:
- IDLE to SETUP, when the region is enabled and either a posted write is waiting or a read is accepted.
- SETUP to LEAD, and LEAD to STROBE, when each phase timer expires.
- STROBE to HOLD, when the timer expires and wait mode is off.
- STROBE to TRAIL, when the timer expires in wait mode with ready high.
- STROBE to STALL, when the timer expires in wait mode with ready low.
- STALL to TRAIL, when ready goes high.
- TRAIL to HOLD, HOLD to GAP, and GAP to IDLE, when each phase timer expires.

Top module: `pbus_cycle_engine`

## Requirements
- R1: After reset, bus_cs_n, bus_oe_n and bus_we_n are high and rsp_done is low. With the region enabled and the buffer empty, req_ready is high.
- R2: A phase whose field holds N lasts (N+1)·M clocks. The multiplier M is selected by cfg_mult: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R3: Each cycle runs in this order. First come cfg_adr units with the address out and chip select high. Then cfg_ce units with chip select low and no strobe. Then the strobe width. Then the hold units with chip select low and no strobe. Then cfg_pause units with chip select high. Exactly one idle clock separates the gap from the next SETUP.
- R4: A read cycle pulses only bus_oe_n for cfg_oe units, and the hold uses cfg_rd_hld. A write cycle pulses only bus_we_n for cfg_we units, and the hold uses cfg_wr_hld. The two strobes are never low together, and neither is low while chip select is high.
- R5: Read data is sampled from bus_rdata on the clock edge at which bus_oe_n returns high. rsp_done is high for exactly one clock, on the clock after the gap ends, and rsp_rdata then holds the sampled data.
- R6: With cfg_wait_mode set, if bus_ready is low when the strobe width ends, the strobe stays asserted until bus_ready is high. It then stays asserted for cfg_wait further units. If bus_ready is already high, only the cfg_wait extension is added.
- R7: With cfg_wait_mode clear, bus_ready has no effect and the strobe lasts exactly its programmed width.
- R8: While cfg_enable is low, no bus cycle starts and req_ready is low.
- R9: The write buffer holds 8 entries. A write request is accepted while the buffer is not full and stalls while it is full. Posted writes reach the bus in acceptance order, with their own address and data.
- R10: A read is accepted only when the write buffer is empty and no bus cycle is in progress, so that every earlier write has finished before the read.
- R11: The address stays stable while chip select is low. bus_data_oe is high for the whole of a write cycle up to the end of its hold and never during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Region enable |
| cfg_wait_mode | input | 1 | Allow bus_ready to stretch the strobe |
| cfg_mult | input | 2 | Timing multiplier code (1, 2, 4 or 8 clocks per unit) |
| cfg_adr | input | FIELD_W | Address setup before chip select, minus one |
| cfg_ce | input | FIELD_W | Chip select to strobe delay, minus one |
| cfg_oe | input | FIELD_W | Read strobe width, minus one |
| cfg_we | input | FIELD_W | Write strobe width, minus one |
| cfg_rd_hld | input | FIELD_W | Hold after read strobe, minus one |
| cfg_wr_hld | input | FIELD_W | Hold after write strobe, minus one |
| cfg_wait | input | FIELD_W | Strobe extension after ready, minus one |
| cfg_pause | input | FIELD_W | Idle gap after chip select release, minus one |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on this clock when valid |
| rsp_done | output | 1 | One-clock read completion pulse |
| rsp_rdata | output | DATA_W | Data of the last read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_data_oe | output | 1 | Drive enable for bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ready | input | 1 | Device ready, low to stretch |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that the configuration inputs do not change while a bus cycle is in progress. They also assume that a requester keeps req_valid and its fields steady until req_ready accepts them. The bench changes configuration only between cycles, after the previous cycle and its done pulse have completed. It drives requests on the falling clock edge and holds them until the handshake. In wait mode, bus_ready is raised only while the strobe is stalled and then left high.

// File: rtl/pbus_cycle_pkg.sv
package pbus_cycle_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_STROBE,
        ST_STALL,
        ST_TRAIL,
        ST_HOLD,
        ST_GAP
    } cyc_state_t;

    localparam int MULT_CODE_W = 2;

    function automatic logic strobe_phase(input cyc_state_t s);
        return (s == ST_STROBE) || (s == ST_STALL) || (s == ST_TRAIL);
    endfunction

    function automatic logic select_phase(input cyc_state_t s);
        return (s == ST_LEAD) || strobe_phase(s) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/pbus_wbuf.sv
module pbus_wbuf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = PW + 1;
    localparam int ENT_W = ADDR_W + DATA_W;

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign {head_addr, head_data} = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {push_addr, push_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] field,
    input  logic [1:0]         mult,
    output logic               expired
);
    localparam int LW = FIELD_W + 4;

    logic [LW-1:0] cnt;
    logic [LW-1:0] span;

    always_comb begin
        span = (({{(LW-FIELD_W){1'b0}}, field} + 1'b1) << mult) - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= span;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pbus_seq_fsm.sv
module pbus_seq_fsm
    import pbus_cycle_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_wait_mode,
    input  logic [FIELD_W-1:0] cfg_adr,
    input  logic [FIELD_W-1:0] cfg_ce,
    input  logic [FIELD_W-1:0] cfg_oe,
    input  logic [FIELD_W-1:0] cfg_we,
    input  logic [FIELD_W-1:0] cfg_rd_hld,
    input  logic [FIELD_W-1:0] cfg_wr_hld,
    input  logic [FIELD_W-1:0] cfg_wait,
    input  logic [FIELD_W-1:0] cfg_pause,
    input  logic               wq_empty,
    input  logic [ADDR_W-1:0]  wq_addr,
    input  logic [DATA_W-1:0]  wq_data,
    output logic               wq_pop,
    input  logic               rd_go,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               tmr_expired,
    output logic               tmr_load,
    output logic [FIELD_W-1:0] tmr_field,
    input  logic               bus_ready,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               idle,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_data_oe,
    output logic               bus_cs_n,
    output logic               bus_oe_n,
    output logic               bus_we_n,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata
);
    cyc_state_t        state, state_nx;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        wq_pop   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cfg_enable && !wq_empty) begin
                    state_nx = ST_SETUP;
                    wq_pop   = 1'b1;
                end else if (rd_go) begin
                    state_nx = ST_SETUP;
                end
            end
            ST_SETUP:  if (tmr_expired) state_nx = ST_LEAD;
            ST_LEAD:   if (tmr_expired) state_nx = ST_STROBE;
            ST_STROBE: begin
                if (tmr_expired) begin
                    if (!cfg_wait_mode)  state_nx = ST_HOLD;
                    else if (bus_ready)  state_nx = ST_TRAIL;
                    else                 state_nx = ST_STALL;
                end
            end
            ST_STALL:  if (bus_ready)   state_nx = ST_TRAIL;
            ST_TRAIL:  if (tmr_expired) state_nx = ST_HOLD;
            ST_HOLD:   if (tmr_expired) state_nx = ST_GAP;
            ST_GAP:    if (tmr_expired) state_nx = ST_IDLE;
        endcase
    end

    // phase field for the timer, chosen by the phase being entered
    always_comb begin
        tmr_load  = (state_nx != state);
        tmr_field = '0;
        unique case (state_nx)
            ST_SETUP:  tmr_field = cfg_adr;
            ST_LEAD:   tmr_field = cfg_ce;
            ST_STROBE: tmr_field = cur_write ? cfg_we : cfg_oe;
            ST_TRAIL:  tmr_field = cfg_wait;
            ST_HOLD:   tmr_field = cur_write ? cfg_wr_hld : cfg_rd_hld;
            ST_GAP:    tmr_field = cfg_pause;
            default:   tmr_field = '0;
        endcase
    end

    // operation latch, read capture and completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (state == ST_IDLE && state_nx == ST_SETUP) begin
                cur_write <= wq_pop;
                cur_addr  <= wq_pop ? wq_addr : rd_addr;
                cur_wdata <= wq_pop ? wq_data : '0;
            end
            if (strobe_phase(state) && state_nx == ST_HOLD && !cur_write)
                rsp_rdata <= bus_rdata;
            rsp_done <= (state == ST_GAP) && (state_nx == ST_IDLE) && !cur_write;
        end
    end

    // outputs
    always_comb begin
        idle        = (state == ST_IDLE);
        bus_addr    = cur_addr;
        bus_wdata   = cur_wdata;
        bus_cs_n    = !select_phase(state);
        bus_oe_n    = !(strobe_phase(state) && !cur_write);
        bus_we_n    = !(strobe_phase(state) && cur_write);
        bus_data_oe = cur_write && (state == ST_SETUP || select_phase(state));
    end
endmodule

// File: rtl/pbus_cycle_engine.sv
module pbus_cycle_engine #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 4,
    parameter int WB_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_wait_mode,
    input  logic [1:0]         cfg_mult,
    input  logic [FIELD_W-1:0] cfg_adr,
    input  logic [FIELD_W-1:0] cfg_ce,
    input  logic [FIELD_W-1:0] cfg_oe,
    input  logic [FIELD_W-1:0] cfg_we,
    input  logic [FIELD_W-1:0] cfg_rd_hld,
    input  logic [FIELD_W-1:0] cfg_wr_hld,
    input  logic [FIELD_W-1:0] cfg_wait,
    input  logic [FIELD_W-1:0] cfg_pause,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_data_oe,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               bus_cs_n,
    output logic               bus_oe_n,
    output logic               bus_we_n
);
    logic              wq_empty, wq_full, wq_pop, wq_push;
    logic [ADDR_W-1:0] wq_addr;
    logic [DATA_W-1:0] wq_data;
    logic              fsm_idle, rd_go, wr_ok, rd_ok;
    logic              tmr_load, tmr_expired;
    logic [FIELD_W-1:0] tmr_field;

    assign wr_ok     = cfg_enable && !wq_full;
    assign rd_ok     = cfg_enable && wq_empty && fsm_idle;
    assign req_ready = req_write ? wr_ok : rd_ok;
    assign wq_push   = req_valid && req_write && wr_ok;
    assign rd_go     = req_valid && !req_write && rd_ok;

    pbus_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wq_push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (wq_pop),
        .head_addr (wq_addr),
        .head_data (wq_data),
        .empty     (wq_empty),
        .full      (wq_full)
    );

    pbus_phase_timer #(.FIELD_W(FIELD_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .field   (tmr_field),
        .mult    (cfg_mult),
        .expired (tmr_expired)
    );

    pbus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enable    (cfg_enable),
        .cfg_wait_mode (cfg_wait_mode),
        .cfg_adr       (cfg_adr),
        .cfg_ce        (cfg_ce),
        .cfg_oe        (cfg_oe),
        .cfg_we        (cfg_we),
        .cfg_rd_hld    (cfg_rd_hld),
        .cfg_wr_hld    (cfg_wr_hld),
        .cfg_wait      (cfg_wait),
        .cfg_pause     (cfg_pause),
        .wq_empty      (wq_empty),
        .wq_addr       (wq_addr),
        .wq_data       (wq_data),
        .wq_pop        (wq_pop),
        .rd_go         (rd_go),
        .rd_addr       (req_addr),
        .tmr_expired   (tmr_expired),
        .tmr_load      (tmr_load),
        .tmr_field     (tmr_field),
        .bus_ready     (bus_ready),
        .bus_rdata     (bus_rdata),
        .idle          (fsm_idle),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_data_oe   (bus_data_oe),
        .bus_cs_n      (bus_cs_n),
        .bus_oe_n      (bus_oe_n),
        .bus_we_n      (bus_we_n),
        .rsp_done      (rsp_done),
        .rsp_rdata     (rsp_rdata)
    );
endmodule

// File: rtl/pbus_cycle_engine_chk.sv
module pbus_cycle_engine_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_data_oe,
    input logic              bus_cs_n,
    input logic              bus_oe_n,
    input logic              bus_we_n
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n)); // R4

    AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_cs_n); // R4

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_data_oe); // R11

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R5

    AST_READ_ON_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ready) |-> (bus_cs_n && bus_we_n && !bus_data_oe)); // R10

    AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> cfg_enable); // R8
endmodule

bind pbus_cycle_engine pbus_cycle_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .bus_addr    (bus_addr),
    .bus_data_oe (bus_data_oe),
    .bus_cs_n    (bus_cs_n),
    .bus_oe_n    (bus_oe_n),
    .bus_we_n    (bus_we_n)
);

// File: tb/pbus_cycle_engine_tb.sv
`timescale 1ns/1ps
module pbus_cycle_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1, cfg_wait_mode = 1'b0;
    logic [1:0]  cfg_mult = 2'd1;
    logic [3:0]  cfg_adr = 4'd0, cfg_ce = 4'd1, cfg_oe = 4'd2, cfg_we = 4'd1;
    logic [3:0]  cfg_rd_hld = 4'd0, cfg_wr_hld = 4'd0, cfg_wait = 4'd0, cfg_pause = 4'd1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, bus_data_oe, bus_cs_n, bus_oe_n, bus_we_n;
    logic [15:0] rsp_rdata, bus_wdata, bus_rdata;
    logic [7:0]  bus_addr;
    logic        bus_ready = 1'b1;
    logic [15:0] rd_pat = 16'h0;

    int checks = 0, fails = 0, cyc = 0;
    int wcount = 0;
    logic [7:0]  wlog_a [64];
    logic [15:0] wlog_d [64];
    logic        prev_we = 1'b1;

    always #10 clk = ~clk;

    assign bus_rdata = bus_oe_n ? 16'h1111 : rd_pat;

    pbus_cycle_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wait_mode(cfg_wait_mode),
        .cfg_mult(cfg_mult), .cfg_adr(cfg_adr), .cfg_ce(cfg_ce), .cfg_oe(cfg_oe),
        .cfg_we(cfg_we), .cfg_rd_hld(cfg_rd_hld), .cfg_wr_hld(cfg_wr_hld),
        .cfg_wait(cfg_wait), .cfg_pause(cfg_pause), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n)
    );

    // log every write strobe as it begins
    always @(negedge clk) begin
        if (prev_we && !bus_we_n && wcount < 64) begin
            wlog_a[wcount] = bus_addr;
            wlog_d[wcount] = bus_wdata;
            wcount = wcount + 1;
        end
        prev_we = bus_we_n;
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic send(input bit wr, input logic [7:0] a, input logic [15:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic measure(output int de_pre, output int cs_low, output int lead,
                           output int oe_c, output int we_c);
        int g = 0;
        de_pre = 0; cs_low = 0; lead = 0; oe_c = 0; we_c = 0;
        while (bus_cs_n && g < 3000) begin
            if (bus_data_oe) de_pre++;
            @(negedge clk); g++;
        end
        while (!bus_cs_n && g < 6000) begin
            cs_low++;
            if (!bus_oe_n) oe_c++;
            if (!bus_we_n) we_c++;
            if (bus_oe_n && bus_we_n && oe_c == 0 && we_c == 0) lead++;
            @(negedge clk); g++;
        end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!rsp_done && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic read_oe_width(input logic [7:0] a, output int oe_c);
        int dp, cs, ld, wc, n;
        send(1'b0, a, 16'h0);
        measure(dp, cs, ld, oe_c, wc);
        wait_done(n);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(bus_cs_n && bus_oe_n && bus_we_n, "R1 strobes idle", {bus_cs_n, bus_oe_n, bus_we_n}, 7);
        chk(!rsp_done, "R1 done low", rsp_done, 0);
        req_write = 1'b1; #1;
        chk(req_ready, "R1 ready", req_ready, 1);
        req_write = 1'b0;
    endtask

    task automatic t_write_basic();
        int dp, cs, ld, oc, wc, base;
        base = wcount;
        send(1'b1, 8'h21, 16'hBEEF);
        measure(dp, cs, ld, oc, wc);
        chk(dp == 2, "R3 address setup", dp, 2);
        chk(ld == 4, "R3 select lead", ld, 4);
        chk(wc == 4, "R2 write strobe width", wc, 4);
        chk(oc == 0, "R4 no read strobe on write", oc, 0);
        chk(cs == 10, "R3 select low span", cs, 10);
        chk(wcount == base + 1 && wlog_a[base] == 8'h21 && wlog_d[base] == 16'hBEEF,
            "R11 write addr/data", int'(wlog_d[base]), 16'hBEEF);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_read_basic();
        int dp, cs, ld, oc, wc, n;
        rd_pat = 16'hA5C3;
        send(1'b0, 8'h40, 16'h0);
        measure(dp, cs, ld, oc, wc);
        chk(oc == 6 && wc == 0, "R4 read strobe width", oc, 6);
        chk(cs == 12 && ld == 4, "R3 read select span", cs, 12);
        chk(dp == 0, "R11 no drive on read", dp, 0);
        wait_done(n);
        chk(n == 4, "R5 done after gap", n, 4);
        chk(rsp_rdata == 16'hA5C3, "R5 captured data", int'(rsp_rdata), 16'hA5C3);
        @(negedge clk);
        chk(!rsp_done, "R5 done one clock", rsp_done, 0);
    endtask

    task automatic t_gap();
        int dp, cs, ld, oc, wc, gap;
        send(1'b1, 8'h31, 16'h0031);
        send(1'b1, 8'h32, 16'h0032);
        measure(dp, cs, ld, oc, wc);
        gap = 0;
        while (bus_cs_n && gap < 500) begin gap++; @(negedge clk); end
        chk(gap == 7, "R3 gap+idle+setup between cycles", gap, 7);
        measure(dp, cs, ld, oc, wc);
        chk(wc == 4, "R9 second posted write", wc, 4);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_mult();
        int w;
        cfg_mult = 2'd0; cfg_oe = 4'd3;
        read_oe_width(8'h50, w);
        chk(w == 4, "R2 mult code 0", w, 4);
        cfg_mult = 2'd2; cfg_oe = 4'd0;
        read_oe_width(8'h51, w);
        chk(w == 4, "R2 mult code 2", w, 4);
        cfg_mult = 2'd3; cfg_oe = 4'd1;
        read_oe_width(8'h52, w);
        chk(w == 16, "R2 mult code 3", w, 16);
        cfg_mult = 2'd1; cfg_oe = 4'd2;
    endtask

    task automatic t_ready_ignored();
        int w;
        cfg_wait_mode = 1'b0; bus_ready = 1'b0;
        read_oe_width(8'h60, w);
        chk(w == 6, "R7 ready ignored", w, 6);
        bus_ready = 1'b1;
    endtask

    task automatic t_wait_stretch();
        int w, n, g;
        cfg_wait_mode = 1'b1; cfg_wait = 4'd1;
        read_oe_width(8'h61, w);
        chk(w == 10, "R6 extension with ready high", w, 10);
        bus_ready = 1'b0;
        send(1'b0, 8'h62, 16'h0);
        g = 0;
        while (bus_oe_n && g < 500) begin @(negedge clk); g++; end
        w = 0;
        while (!bus_oe_n && w < 500) begin
            w++;
            if (w == 15) bus_ready = 1'b1;
            @(negedge clk);
        end
        chk(w == 19, "R6 stall then extension", w, 19);
        wait_done(n);
        @(negedge clk);
        cfg_wait_mode = 1'b0; cfg_wait = 4'd0;
    endtask

    task automatic t_disable();
        int bad, dp, cs, ld, oc, wc;
        bad = 0;
        cfg_enable = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h55; req_wdata = 16'h5555;
        repeat (20) begin
            @(negedge clk);
            if (!bus_cs_n || req_ready) bad++;
        end
        chk(bad == 0, "R8 disabled region silent", bad, 0);
        cfg_enable = 1'b1;
        send(1'b1, 8'h55, 16'h5555);
        measure(dp, cs, ld, oc, wc);
        chk(wc == 4, "R8 cycle after enable", wc, 4);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_fifo();
        int acc, stall_at, base, bad, dp, cs, ld, oc, wc, n;
        base = wcount; acc = 0; stall_at = -1;
        req_valid = 1'b1; req_write = 1'b1;
        while (acc < 10) begin
            req_addr = 8'h80 + 8'(acc); req_wdata = 16'h1000 + 16'(acc);
            #1;
            if (req_ready) begin
                @(negedge clk); acc++;
            end else begin
                if (stall_at < 0) stall_at = acc;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(stall_at == 9, "R9 stall when buffer full", stall_at, 9);
        rd_pat = 16'h7E81;
        send(1'b0, 8'h90, 16'h0);
        chk(wcount - base == 10 && bus_we_n, "R10 read after drain", wcount - base, 10);
        bad = 0;
        for (int i = 0; i < 10; i++)
            if (wlog_a[base+i] != 8'h80 + 8'(i) || wlog_d[base+i] != 16'h1000 + 16'(i)) bad++;
        chk(bad == 0, "R9 posted order", bad, 0);
        measure(dp, cs, ld, oc, wc);
        wait_done(n);
        chk(rsp_rdata == 16'h7E81, "R10 read data after writes", int'(rsp_rdata), 16'h7E81);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_basic();
        t_gap();
        t_mult();
        t_ready_ignored();
        t_wait_stretch();
        t_disable();
        t_fifo();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule